// File: doc/BRIEF.md
# External-memory FIFO pointer controller

This block does the bookkeeping for a first-in first-out queue whose storage sits in an external, word-addressed memory region such as a slice of DRAM. It holds no payload data. A data mover that pushes words into the region pulses a write strobe for each word. A data mover that pulls words out pulses a read strobe. The controller answers with the address at which the next word should be written, the address from which the next word should be read, the number of words currently held, and two registered flags that say whether reading or writing may proceed.

The region begins at a configurable base address and holds a fixed number of words. Both pointers wrap back to the base once they pass the last word. The flags are not plain empty and full indications. Each is compared against its own threshold, so a consumer can wait until a burst's worth of data is present, and a producer can be stopped before the region is completely full. A strobe that arrives while its flag is low is dropped. All state is reset synchronously by an active-low reset.

Top module: `ext_fifo_ptr_ctrl`

## Requirements
- R1: While reset is low at a clock edge, and on the cycle after it, `level_o` is 0, both `wr_addr_o` and `rd_addr_o` equal `BASE_ADDR`, `readable_o` is 0, and `writable_o` is 1 whenever `WRITE_THRESH` is non-zero.
- R2: An accepted write with no accepted read in the same cycle raises `level_o` by exactly 1, visible in the cycle after the strobe is sampled.
- R3: An accepted read with no accepted write in the same cycle lowers `level_o` by exactly 1, visible in the cycle after the strobe is sampled.
- R4: When a write and a read are both accepted in one cycle, `level_o` is unchanged and both addresses advance.
- R5: Each address output equals `BASE_ADDR` plus a pointer that counts accepted strobes of its own kind modulo `DEPTH`. Depth 16 with base 8 gives addresses 8 to 23, and 24 writes leave the write address at 16. The new address appears one clock after the strobe.
- R6: `readable_o` is 1 exactly when `level_o` is greater than `READ_THRESH`. `writable_o` is 1 exactly when `level_o` is less than `WRITE_THRESH`. Both flags are registers and always agree with the `level_o` of the same cycle. The defaults are `READ_THRESH` = 0 and `WRITE_THRESH` = `DEPTH`.
- R7: A write strobe sampled while `writable_o` is 0 is ignored. `wr_addr_o` and `level_o` stay as they were, except for the effect of an accepted read in the same cycle.
- R8: A read strobe sampled while `readable_o` is 0 is ignored. `rd_addr_o` and `level_o` stay as they were, except for the effect of an accepted write in the same cycle.
- R9: `level_o` is `$clog2(DEPTH)+1` bits wide. It reaches the full value `DEPTH` and never exceeds it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_i | input | 1 | One-cycle request to commit one word at `wr_addr_o` |
| rd_i | input | 1 | One-cycle request to consume one word at `rd_addr_o` |
| wr_addr_o | output | ADDR_W | Region address for the next write |
| rd_addr_o | output | ADDR_W | Region address for the next read |
| level_o | output | $clog2(DEPTH)+1 | Number of words currently held |
| readable_o | output | 1 | Level is above the read threshold |
| writable_o | output | 1 | Level is below the write threshold |

## Verification
The hardest situations to reach are the strobes that must be dropped. They need a write issued when the level has already reached the write threshold, and a read, or a write and read together, issued when the level is at or below the read threshold. A pointer also has to wrap at the same moment as one of these drops. The stimulus fills the region with a long run of writes, keeps writing against the full flag, drains it past empty, and then runs long biased random phases that hover near either end. A second instance has a depth that is not a power of two and thresholds inside the range, so the thresholds and the wrap point do not line up.

// File: rtl/efp_pkg.sv
// Package: shared sizing helpers for the external-memory FIFO pointer controller.
// Assumes depths of at least 2 words.
package efp_pkg;

    // Width of a pointer that indexes DEPTH words.
    function automatic int ptr_width(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

    // Width of a fill counter that must also hold the value DEPTH itself.
    function automatic int level_width(input int depth);
        return ptr_width(depth) + 1;
    endfunction

endpackage

// File: rtl/efp_wrap_ptr.sv
// Module: efp_wrap_ptr
// Counts accepted strobes modulo DEPTH and presents BASE plus that count as a
// registered address. The caller gates adv_i with the relevant flag. DEPTH need
// not be a power of two. Assumes BASE + DEPTH - 1 fits in ADDR_W bits.
module efp_wrap_ptr #(
    parameter int unsigned             DEPTH  = 16,
    parameter int unsigned             ADDR_W = 32,
    parameter logic [ADDR_W-1:0]       BASE   = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int PTR_W = efp_pkg::ptr_width(int'(DEPTH));
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [PTR_W-1:0]  ptr_q;
    logic [PTR_W-1:0]  ptr_nxt;
    logic [ADDR_W-1:0] addr_q;

    // Next pointer value: step by one and fold back to zero after the last word.
    always_comb begin
        ptr_nxt = ptr_q;
        if (adv_i) begin
            ptr_nxt = (ptr_q == LAST) ? '0 : ptr_q + PTR_W'(1);
        end
    end

    // Pointer and address registers: the address is kept as base plus offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            addr_q <= BASE;
        end else begin
            ptr_q  <= ptr_nxt;
            addr_q <= BASE + ADDR_W'(ptr_nxt);
        end
    end

    assign addr_o = addr_q;

    // R5: the address never leaves the region.
    assert_addr_in_region_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_q >= BASE) && (addr_q <= BASE + ADDR_W'(DEPTH - 1)));

    // R5: without an accepted strobe the address holds.
    assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(addr_q));

    // R5: after the last word the address folds back to the base.
    assert_addr_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && addr_q == BASE + ADDR_W'(DEPTH - 1)) |=> (addr_q == BASE));

endmodule

// File: rtl/efp_level_track.sv
// Module: efp_level_track
// Holds the fill level and the two threshold flags. The flags are computed from
// the next level, so they are registered yet agree with level_o every cycle.
// Assumes inc_i and dec_i are already gated: an increment is never presented at
// level DEPTH and a decrement is never presented at level 0.
module efp_level_track #(
    parameter int unsigned DEPTH        = 16,
    parameter int unsigned READ_THRESH  = 0,
    parameter int unsigned WRITE_THRESH = DEPTH
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       inc_i,
    input  logic                                       dec_i,
    output logic [efp_pkg::level_width(int'(DEPTH))-1:0] level_o,
    output logic                                       readable_o,
    output logic                                       writable_o
);
    localparam int LVL_W = efp_pkg::level_width(int'(DEPTH));
    localparam logic WR_OK_AT_ZERO = (WRITE_THRESH != 0);

    logic [LVL_W-1:0] level_q;
    logic [LVL_W-1:0] level_nxt;
    logic             readable_q;
    logic             writable_q;

    // Next level: up on a lone increment, down on a lone decrement, else hold.
    always_comb begin
        unique case ({inc_i, dec_i})
            2'b10:   level_nxt = level_q + LVL_W'(1);
            2'b01:   level_nxt = level_q - LVL_W'(1);
            default: level_nxt = level_q;
        endcase
    end

    // Level and flag registers, updated together so they never disagree.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q    <= '0;
            readable_q <= 1'b0;
            writable_q <= WR_OK_AT_ZERO;
        end else begin
            level_q    <= level_nxt;
            readable_q <= (32'(level_nxt) > READ_THRESH);
            writable_q <= (32'(level_nxt) < WRITE_THRESH);
        end
    end

    assign level_o    = level_q;
    assign readable_o = readable_q;
    assign writable_o = writable_q;

    // R9: the level never goes above the region depth.
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        32'(level_q) <= DEPTH);

    // R2: a lone increment adds exactly one.
    assert_level_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !dec_i) |=> (level_q == $past(level_q) + LVL_W'(1)));

    // R3: a lone decrement removes exactly one.
    assert_level_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !inc_i) |=> (level_q == $past(level_q) - LVL_W'(1)));

    // R4: both at once leave the level alone.
    assert_level_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && dec_i) |=> $stable(level_q));

    // R6: each flag agrees with the level held in the same cycle.
    assert_flags_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (readable_q == (32'(level_q) > READ_THRESH)) &&
        (writable_q == (32'(level_q) < WRITE_THRESH)));

endmodule

// File: rtl/ext_fifo_ptr_ctrl.sv
// Module: ext_fifo_ptr_ctrl (top)
// Pointer and level controller for a FIFO stored in an external word-addressed
// region [BASE_ADDR, BASE_ADDR + DEPTH). Strobes are gated by the registered
// flags, and the gated strobes drive two wrapping pointers and the level tracker.
// Assumes one-cycle strobes from the data movers and a DEPTH of at least 2.
module ext_fifo_ptr_ctrl #(
    parameter int unsigned       DEPTH        = 16,
    parameter int unsigned       ADDR_W       = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR    = '0,
    parameter int unsigned       READ_THRESH  = 0,
    parameter int unsigned       WRITE_THRESH = DEPTH
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic                                         wr_i,
    input  logic                                         rd_i,
    output logic [ADDR_W-1:0]                            wr_addr_o,
    output logic [ADDR_W-1:0]                            rd_addr_o,
    output logic [efp_pkg::level_width(int'(DEPTH))-1:0] level_o,
    output logic                                         readable_o,
    output logic                                         writable_o
);
    localparam int LVL_W = efp_pkg::level_width(int'(DEPTH));

    logic             wr_take;
    logic             rd_take;
    logic [LVL_W-1:0] level_w;
    logic             readable_w;
    logic             writable_w;

    // Acceptance: a strobe counts only while its flag allows it.
    always_comb begin
        wr_take = wr_i && writable_w;
        rd_take = rd_i && readable_w;
    end

    efp_wrap_ptr #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W),
        .BASE   (BASE_ADDR)
    ) u_wr_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv_i  (wr_take),
        .addr_o (wr_addr_o)
    );

    efp_wrap_ptr #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W),
        .BASE   (BASE_ADDR)
    ) u_rd_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv_i  (rd_take),
        .addr_o (rd_addr_o)
    );

    efp_level_track #(
        .DEPTH        (DEPTH),
        .READ_THRESH  (READ_THRESH),
        .WRITE_THRESH (WRITE_THRESH)
    ) u_level (
        .clk        (clk),
        .rst_n      (rst_n),
        .inc_i      (wr_take),
        .dec_i      (rd_take),
        .level_o    (level_w),
        .readable_o (readable_w),
        .writable_o (writable_w)
    );

    assign level_o    = level_w;
    assign readable_o = readable_w;
    assign writable_o = writable_w;

    // R1: in the cycle after a reset edge the outputs show the reset state.
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (level_o == '0) && (wr_addr_o == BASE_ADDR) &&
                   (rd_addr_o == BASE_ADDR) && !readable_o);

    // R7: a write refused by the flag moves neither the write address nor the level.
    assert_write_refused_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !writable_o && !rd_i) |=> ($stable(wr_addr_o) && $stable(level_o)));

    // R8: a read refused by the flag moves neither the read address nor the level.
    assert_read_refused_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !readable_o && !wr_i) |=> ($stable(rd_addr_o) && $stable(level_o)));

    // R4: an accepted pair moves both addresses.
    assert_pair_moves_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && writable_o && rd_i && readable_o) |=>
            (!$stable(wr_addr_o) && !$stable(rd_addr_o)));

endmodule

// File: tb/ext_fifo_ptr_ctrl_bench.sv
// Bench: two instances driven by the same strobes, each compared on every
// clock against a behavioural model that uses plain integers.
module ext_fifo_ptr_ctrl_bench;
    localparam int AW = 16;
    // Instance 0: base 8, depth 16, default thresholds.
    localparam int D0 = 16, B0 = 8,   RT0 = 0, WT0 = 16;
    // Instance 1: base 100, depth 6, thresholds inside the range.
    localparam int D1 = 6,  B1 = 100, RT1 = 2, WT1 = 5;
    localparam int LW0 = efp_pkg::level_width(D0);
    localparam int LW1 = efp_pkg::level_width(D1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr = 1'b0;
    logic rd = 1'b0;

    logic [AW-1:0]  wa0, ra0, wa1, ra1;
    logic [LW0-1:0] lv0;
    logic [LW1-1:0] lv1;
    logic           rdbl0, wrbl0, rdbl1, wrbl1;

    int checks = 0;
    int failures = 0;
    bit armed = 1'b0;
    bit done = 1'b0;

    // Model state per instance.
    int m_lvl[2];
    int m_wp[2];
    int m_rp[2];
    int p_d[2]  = '{D0, D1};
    int p_b[2]  = '{B0, B1};
    int p_rt[2] = '{RT0, RT1};
    int p_wt[2] = '{WT0, WT1};

    always #10 clk = ~clk;

    ext_fifo_ptr_ctrl #(
        .DEPTH(D0), .ADDR_W(AW), .BASE_ADDR(AW'(B0)),
        .READ_THRESH(RT0), .WRITE_THRESH(WT0)
    ) u_ext_fifo_ptr_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_i(wr), .rd_i(rd),
        .wr_addr_o(wa0), .rd_addr_o(ra0), .level_o(lv0),
        .readable_o(rdbl0), .writable_o(wrbl0)
    );

    ext_fifo_ptr_ctrl #(
        .DEPTH(D1), .ADDR_W(AW), .BASE_ADDR(AW'(B1)),
        .READ_THRESH(RT1), .WRITE_THRESH(WT1)
    ) u_ext_fifo_ptr_ctrl_thr (
        .clk(clk), .rst_n(rst_n), .wr_i(wr), .rd_i(rd),
        .wr_addr_o(wa1), .rd_addr_o(ra1), .level_o(lv1),
        .readable_o(rdbl1), .writable_o(wrbl1)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Model update at each active edge, from the same strobes the design sees.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 2; k++) begin
                m_lvl[k] = 0; m_wp[k] = 0; m_rp[k] = 0;
            end
            armed <= 1'b1;
        end else begin
            for (int k = 0; k < 2; k++) begin
                bit tw, tr;
                tw = wr && (m_lvl[k] < p_wt[k]);
                tr = rd && (m_lvl[k] > p_rt[k]);
                m_lvl[k] = m_lvl[k] + int'(tw) - int'(tr);
                m_wp[k] = (m_wp[k] + int'(tw)) % p_d[k];
                m_rp[k] = (m_rp[k] + int'(tr)) % p_d[k];
            end
        end
    end

    // Compare every output against the model away from the active edge.
    always @(negedge clk) begin
        if (armed && !done) begin
            check("R2/R3/R4", "u0 level", int'(lv0), m_lvl[0]);
            check("R5", "u0 wr_addr", int'(wa0), p_b[0] + m_wp[0]);
            check("R5", "u0 rd_addr", int'(ra0), p_b[0] + m_rp[0]);
            check("R6", "u0 readable", int'(rdbl0), int'(m_lvl[0] > p_rt[0]));
            check("R6", "u0 writable", int'(wrbl0), int'(m_lvl[0] < p_wt[0]));
            check("R2/R3/R4", "u1 level", int'(lv1), m_lvl[1]);
            check("R5", "u1 wr_addr", int'(wa1), p_b[1] + m_wp[1]);
            check("R5", "u1 rd_addr", int'(ra1), p_b[1] + m_rp[1]);
            check("R6", "u1 readable", int'(rdbl1), int'(m_lvl[1] > p_rt[1]));
            check("R6", "u1 writable", int'(wrbl1), int'(m_lvl[1] < p_wt[1]));
        end
    end

    task automatic drive(input bit w, input bit r);
        @(negedge clk);
        wr = w;
        rd = r;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int cap;
        repeat (3) drive(0, 0);
        // R1: reset state, seen one cycle after a reset edge.
        check("R1", "level after reset", int'(lv0), 0);
        check("R1", "wr_addr after reset", int'(wa0), B0);
        check("R1", "rd_addr after reset", int'(ra0), B0);
        check("R1", "readable after reset", int'(rdbl0), 0);
        check("R1", "writable after reset", int'(wrbl0), 1);
        drive(0, 0);
        rst_n = 1'b1;

        // R2: three lone writes.
        repeat (3) drive(1, 0);
        drive(0, 0);
        check("R2", "level after 3 writes", int'(lv0), 3);
        check("R2", "wr_addr after 3 writes", int'(wa0), B0 + 3);

        // R4: two paired strobes keep the level and move both addresses.
        repeat (2) drive(1, 1);
        drive(0, 0);
        check("R4", "level after pairs", int'(lv0), 3);
        check("R4", "wr_addr after pairs", int'(wa0), B0 + 5);
        check("R4", "rd_addr after pairs", int'(ra0), B0 + 2);

        // R3: three lone reads empty the queue.
        repeat (3) drive(0, 1);
        drive(0, 0);
        check("R3", "level after 3 reads", int'(lv0), 0);
        check("R3", "rd_addr after 3 reads", int'(ra0), B0 + 5);

        // R8: a read at empty is dropped.
        cap = int'(ra0);
        drive(0, 1);
        drive(0, 0);
        check("R8", "level after read at empty", int'(lv0), 0);
        check("R8", "rd_addr after read at empty", int'(ra0), cap);

        // R9: fill to the full depth; the write pointer wraps on the way (R5).
        repeat (16) drive(1, 0);
        drive(0, 0);
        check("R9", "level at full", int'(lv0), 16);
        check("R9", "writable at full", int'(wrbl0), 0);
        check("R5", "wr_addr wrapped", int'(wa0), B0 + 5);
        check("R6", "u1 level capped by write threshold", int'(lv1), 5);

        // R7: a write at full is dropped.
        cap = int'(wa0);
        drive(1, 0);
        drive(0, 0);
        check("R7", "level after write at full", int'(lv0), 16);
        check("R7", "wr_addr after write at full", int'(wa0), cap);

        // R7: a pair at full takes only the read.
        drive(1, 1);
        drive(0, 0);
        check("R7", "level after pair at full", int'(lv0), 15);
        check("R7", "wr_addr after pair at full", int'(wa0), cap);

        // Drain, then long biased random phases around both ends.
        repeat (15) drive(0, 1);
        for (int ph = 0; ph < 6; ph++) begin
            for (int i = 0; i < 500; i++) begin
                int w_pct;
                w_pct = (ph % 2 == 0) ? 75 : 25;
                drive(($urandom % 100) < w_pct, ($urandom % 100) >= w_pct);
                if (($urandom % 8) == 0) drive(1, 1);
            end
        end

        // Mid-run reset returns to the reset state (R1).
        drive(0, 0);
        rst_n = 1'b0;
        drive(0, 0);
        drive(0, 0);
        check("R1", "level after second reset", int'(lv0), 0);
        check("R1", "wr_addr after second reset", int'(wa0), B0);
        check("R1", "u1 rd_addr after second reset", int'(ra1), B1);
        rst_n = 1'b1;
        repeat (4) drive(0, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule